// File: doc/BRIEF.md
# In-Band Loop Code Detector

This block watches an unframed serial bit stream for a repeating loop-up or loop-down code. Every bit of the stream belongs to the code. The stream is split into fixed windows of `WIN_BITS` enabled bits, 51200 by default. Each window is judged as loop-up, loop-down or neither. A window qualifies for a code when, for at least one phase alignment of that code, it holds no more than `ERR_MAX` mismatching bits. The default of 512 errors is 1 % of the window.

Each qualifying window raises a one-cycle status pulse for its code. The pulse does not depend on the detection-time setting or on the automatic-switching enable. A separate run counter counts consecutive windows of the same code. When the run reaches the number of windows chosen by the detection-time setting, and automatic switching is enabled, the internal loop state is set by a loop-up run or cleared by a loop-down run. The loop output ORs this state with a software loop request.

The codes are either fixed or programmable. In programmable mode each code has its own register and its own length field. Pattern lengths should only be changed while the block is held in reset.

Top module: `ilc_detector`

## Requirements
- R1: A window closes on its `WIN_BITS`-th enabled bit (`bit_en` high). Cycles with `bit_en` low leave the data and the counters unchanged. Status pulses and loop changes occur only in the cycle after a window's last bit.
- R2: A window qualifies for a code when its mismatch count, taken at the best phase alignment of that code, is at most `ERR_MAX`. A count of `ERR_MAX`+1 at every alignment does not qualify.
- R3: `up_seen` is high for exactly one cycle after a window that qualifies as loop-up. `dn_seen` does the same for loop-down. Loop-up wins if both qualify, and the two pulses never overlap. Neither pulse depends on `auto_en` or `det_sel`.
- R4: With `prog_mode`=0 the loop-up code is the repeating 5-bit `00001` and the loop-down code is the repeating 3-bit `001`.
- R5: With `prog_mode`=1 a code's length is its length field plus 2, and a field value of 7 means 8. The code is bits [len-1:0] of its pattern register, sent MSB first and repeated.
- R6: `det_sel` chooses how many consecutive windows of the same code switch the loop: 00 means 16, 01 means 8, 10 means 4 and 11 means 2. A window of neither code, or of the other code, restarts the count.
- R7: Only when `auto_en`=1 does a completed loop-up run set the internal loop state and a completed loop-down run clear it. With `auto_en`=0 the loop state holds its value.
- R8: `loop_out` is the internal loop state ORed with `sw_loop`, with no added delay.
- R9: While `rst_n` is low, `up_seen`, `dn_seen` and `loop_out` (with `sw_loop`=0) are 0. The loop state starts inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Marks a valid stream bit on `bit_in` |
| bit_in | input | 1 | Serial stream bit |
| prog_mode | input | 1 | 1: programmable codes, 0: fixed codes |
| up_pat | input | MAX_LEN | Programmable loop-up code |
| up_len | input | FW | Loop-up length minus 2 |
| dn_pat | input | MAX_LEN | Programmable loop-down code |
| dn_len | input | FW | Loop-down length minus 2 |
| det_sel | input | 2 | Consecutive-window requirement for switching |
| auto_en | input | 1 | Enables automatic loop switching |
| sw_loop | input | 1 | Software loop request |
| up_seen | output | 1 | One-cycle pulse after a loop-up window |
| dn_seen | output | 1 | One-cycle pulse after a loop-down window |
| loop_out | output | 1 | Loop activate |

## Verification
A wrong window position or stuck phase counter shows up at the end of the first affected window. It appears there as a missing or extra status pulse, or as a pulse in the wrong cycle. A wrong run count or detection-time decode only shows up at the window where the loop should, or should not, switch. That can be up to 16 windows later. Error-threshold faults are exposed by windows that carry exactly `ERR_MAX` and `ERR_MAX`+1 errors, which differ by a single bit.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_UP   = 2'd1,
    CODE_DOWN = 2'd2
  } code_e;

  // Consecutive qualifying windows needed before a switch
  function automatic logic [4:0] windows_needed(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd16;
      2'b01:   return 5'd8;
      2'b10:   return 5'd4;
      default: return 5'd2;
    endcase
  endfunction

endpackage

// File: rtl/ilc_window.sv
module ilc_window #(
  parameter int WIN_BITS = 51200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  output logic win_last
);
  localparam int CW = $clog2(WIN_BITS);

  logic [CW-1:0] cnt_q, cnt_d;

  assign win_last = bit_en && (cnt_q == CW'(WIN_BITS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (bit_en) cnt_d = win_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WIN_BITS)); // R1
  AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/ilc_matcher.sv
module ilc_matcher #(
  parameter int WIN_BITS = 51200,
  parameter int ERR_MAX  = 512,
  parameter int MAX_LEN  = 8,
  parameter int LW       = $clog2(MAX_LEN) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  input  logic               win_last,
  input  logic [MAX_LEN-1:0] pat,
  input  logic [LW-1:0]      len,
  output logic               hit
);
  localparam int IW = $clog2(MAX_LEN);
  localparam int CW = $clog2(WIN_BITS + 1);

  logic [IW-1:0]      pos_q, pos_d;
  logic [MAX_LEN-1:0] ph_ok;

  // Stream position modulo pattern length
  always_comb begin
    pos_d = pos_q;
    if (bit_en) pos_d = (LW'(pos_q) + LW'(1) >= len) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // One mismatch counter per phase alignment
  for (genvar p = 0; p < MAX_LEN; p++) begin : g_ph
    logic [LW-1:0] sum, idx;
    logic [IW-1:0] sel;
    logic          mis;
    logic [CW-1:0] err_q, err_d, tot;

    assign sum = LW'(pos_q) + LW'(p);
    assign idx = (sum >= len) ? sum - len : sum;
    assign sel = IW'(len - idx - LW'(1));
    assign mis = bit_in ^ pat[sel];
    assign tot = err_q + CW'(mis);
    assign ph_ok[p] = (LW'(p) < len) && (tot <= CW'(ERR_MAX));

    always_comb begin
      err_d = err_q;
      if (win_last)    err_d = '0;
      else if (bit_en) err_d = tot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= err_d;
    end

    AST_ERR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      win_last |=> err_q == '0); // R1
  end

  // Any phase within the limit is the same as the minimum being within it
  assign hit = win_last && (|ph_ok);

  AST_HIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> bit_en); // R2

endmodule

// File: rtl/ilc_switch.sv
module ilc_switch
  import ilc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_last,
  input  logic       up_hit,
  input  logic       dn_hit,
  input  logic [1:0] det_sel,
  input  logic       auto_en,
  output logic       up_seen,
  output logic       dn_seen,
  output logic       loop_act
);
  code_e      run_q, run_d, now;
  logic [4:0] cnt_q, cnt_d, need;
  logic       up_d, dn_d, loop_d;

  assign need = windows_needed(det_sel);
  assign now  = up_hit ? CODE_UP : (dn_hit ? CODE_DOWN : CODE_NONE);

  always_comb begin
    up_d   = 1'b0;
    dn_d   = 1'b0;
    run_d  = run_q;
    cnt_d  = cnt_q;
    loop_d = loop_act;
    if (win_last) begin
      up_d = (now == CODE_UP);
      dn_d = (now == CODE_DOWN);
      if (now == CODE_NONE) begin
        run_d = CODE_NONE;
        cnt_d = '0;
      end else if (now == run_q) begin
        cnt_d = (cnt_q >= need) ? cnt_q : cnt_q + 1'b1;
      end else begin
        run_d = now;
        cnt_d = 5'd1;
      end
      if (auto_en && (now != CODE_NONE) && (cnt_d >= need))
        loop_d = (now == CODE_UP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= CODE_NONE;
      cnt_q    <= '0;
      up_seen  <= 1'b0;
      dn_seen  <= 1'b0;
      loop_act <= 1'b0;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      up_seen  <= up_d;
      dn_seen  <= dn_d;
      loop_act <= loop_d;
    end
  end

  AST_ONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_seen && dn_seen)); // R3
  AST_AUTO_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> $stable(loop_act)); // R7
  AST_LOOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_act) |-> up_seen); // R6
  AST_LOOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_act) |-> dn_seen); // R6
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !up_hit && !dn_hit) |=> cnt_q == '0); // R6

endmodule

// File: rtl/ilc_detector.sv
module ilc_detector #(
  parameter int WIN_BITS = 51200,
  parameter int ERR_MAX  = 512,
  parameter int MAX_LEN  = 8,
  parameter int FW       = $clog2(MAX_LEN - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  input  logic               prog_mode,
  input  logic [MAX_LEN-1:0] up_pat,
  input  logic [FW-1:0]      up_len,
  input  logic [MAX_LEN-1:0] dn_pat,
  input  logic [FW-1:0]      dn_len,
  input  logic [1:0]         det_sel,
  input  logic               auto_en,
  input  logic               sw_loop,
  output logic               up_seen,
  output logic               dn_seen,
  output logic               loop_out
);
  localparam int LW = $clog2(MAX_LEN) + 1;
  localparam logic [MAX_LEN-1:0] FIX_UP_PAT = MAX_LEN'(5'b00001);
  localparam logic [MAX_LEN-1:0] FIX_DN_PAT = MAX_LEN'(3'b001);
  localparam logic [LW-1:0]      FIX_UP_LEN = LW'(5);
  localparam logic [LW-1:0]      FIX_DN_LEN = LW'(3);

  function automatic logic [LW-1:0] decode_len(input logic [FW-1:0] f);
    int v;
    v = int'(f) + 2;
    if (v > MAX_LEN) v = MAX_LEN;
    return LW'(v);
  endfunction

  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic               win_last, up_hit, dn_hit, loop_act;
  logic [MAX_LEN-1:0] up_code, dn_code;
  logic [LW-1:0]      up_size, dn_size;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign up_code = prog_mode ? up_pat : FIX_UP_PAT;
  assign dn_code = prog_mode ? dn_pat : FIX_DN_PAT;
  assign up_size = prog_mode ? decode_len(up_len) : FIX_UP_LEN;
  assign dn_size = prog_mode ? decode_len(dn_len) : FIX_DN_LEN;

  ilc_window #(.WIN_BITS(WIN_BITS)) i_window (
    .clk(clk), .rst_n(rst_n_int), .bit_en(bit_en), .win_last(win_last)
  );

  ilc_matcher #(.WIN_BITS(WIN_BITS), .ERR_MAX(ERR_MAX), .MAX_LEN(MAX_LEN), .LW(LW)) i_match_up (
    .clk(clk), .rst_n(rst_n_int), .bit_en(bit_en), .bit_in(bit_in),
    .win_last(win_last), .pat(up_code), .len(up_size), .hit(up_hit)
  );

  ilc_matcher #(.WIN_BITS(WIN_BITS), .ERR_MAX(ERR_MAX), .MAX_LEN(MAX_LEN), .LW(LW)) i_match_dn (
    .clk(clk), .rst_n(rst_n_int), .bit_en(bit_en), .bit_in(bit_in),
    .win_last(win_last), .pat(dn_code), .len(dn_size), .hit(dn_hit)
  );

  ilc_switch i_switch (
    .clk(clk), .rst_n(rst_n_int), .win_last(win_last),
    .up_hit(up_hit), .dn_hit(dn_hit), .det_sel(det_sel), .auto_en(auto_en),
    .up_seen(up_seen), .dn_seen(dn_seen), .loop_act(loop_act)
  );

  assign loop_out = loop_act | sw_loop;

  AST_PULSE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (up_seen || dn_seen) |-> $past(bit_en)); // R1

endmodule

// File: tb/test_ilc_detector.sv
module test_ilc_detector;
  localparam int WIN  = 100;
  localparam int EMAX = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, bit_in = 1'b0, prog_mode = 1'b0;
  logic [7:0] up_pat = '0, dn_pat = '0;
  logic [2:0] up_len = '0, dn_len = '0;
  logic [1:0] det_sel = 2'b11;
  logic       auto_en = 1'b0, sw_loop = 1'b0;
  logic       up_seen, dn_seen, loop_out;

  int checks = 0, errors = 0;
  int up_cnt = 0, dn_cnt = 0;
  int gap_mode = 0;
  int gpos = 0;

  always #2.5 clk = ~clk;

  ilc_detector #(.WIN_BITS(WIN), .ERR_MAX(EMAX), .MAX_LEN(8)) i_ilc_detector (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .prog_mode(prog_mode), .up_pat(up_pat), .up_len(up_len),
    .dn_pat(dn_pat), .dn_len(dn_len), .det_sel(det_sel),
    .auto_en(auto_en), .sw_loop(sw_loop),
    .up_seen(up_seen), .dn_seen(dn_seen), .loop_out(loop_out)
  );

  // ---------------- reference model ----------------
  function automatic int eff_len(input int kind);
    int v;
    if (!prog_mode) return (kind == 0) ? 5 : 3;
    v = ((kind == 0) ? int'(up_len) : int'(dn_len)) + 2;
    return (v > 8) ? 8 : v;
  endfunction

  function automatic logic eff_bit(input int kind, input int k);
    int L;
    logic [7:0] pv;
    L  = eff_len(kind);
    pv = !prog_mode ? 8'b0000_0001 : ((kind == 0) ? up_pat : dn_pat);
    return pv[L - 1 - (k % L)];
  endfunction

  logic winq[$];
  int   kbase = 0, kcnt = 0, run_code = 0, run_len = 0;
  logic exp_up = 1'b0, exp_dn = 1'b0, exp_loop = 1'b0;

  function automatic int best_err(input int kind);
    int best, e, L;
    L = eff_len(kind);
    best = 1 << 30;
    for (int p = 0; p < L; p++) begin
      e = 0;
      for (int i = 0; i < winq.size(); i++)
        if (winq[i] != eff_bit(kind, kbase + i + p)) e++;
      if (e < best) best = e;
    end
    return best;
  endfunction

  function automatic int need_of(input logic [1:0] s);
    return (s == 2'b00) ? 16 : (s == 2'b01) ? 8 : (s == 2'b10) ? 4 : 2;
  endfunction

  always @(posedge clk) begin
    int code;
    exp_up = 1'b0;
    exp_dn = 1'b0;
    if (!rst_n) begin
      winq.delete();
      kbase = 0; kcnt = 0; run_code = 0; run_len = 0; exp_loop = 1'b0;
    end else if (bit_en) begin
      winq.push_back(bit_in);
      kcnt++;
      if (winq.size() == WIN) begin
        code = (best_err(0) <= EMAX) ? 1 : (best_err(1) <= EMAX) ? 2 : 0;
        exp_up = (code == 1);
        exp_dn = (code == 2);
        if (code == 0) run_len = 0;
        else if (code == run_code) run_len++;
        else begin run_code = code; run_len = 1; end
        if (code != 0 && auto_en && run_len >= need_of(det_sel))
          exp_loop = (code == 1);
        kbase = kcnt;
        winq.delete();
      end
    end
  end

  // Compare every cycle, away from the clock edge
  always @(negedge clk) begin
    #1;
    checks++;
    if (up_seen !== exp_up) begin
      errors++; $display("FAIL R3 up_seen actual %b expected %b", up_seen, exp_up);
    end
    checks++;
    if (dn_seen !== exp_dn) begin
      errors++; $display("FAIL R3 dn_seen actual %b expected %b", dn_seen, exp_dn);
    end
    checks++;
    if (loop_out !== (exp_loop | sw_loop)) begin
      errors++; $display("FAIL R6 loop_out actual %b expected %b", loop_out, exp_loop | sw_loop);
    end
    if (up_seen === 1'b1) up_cnt++;
    if (dn_seen === 1'b1) dn_cnt++;
  end

  // ---------------- stimulus ----------------
  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gpos = 0;
    repeat (4) @(negedge clk);
  endtask

  // kind 0: loop-up, 1: loop-down, 2: all ones
  task automatic send_window(input int kind, input int nerr);
    logic b;
    for (int i = 0; i < WIN; i++) begin
      b = (kind == 2) ? 1'b1 : eff_bit(kind, gpos);
      if (i % 10 == 0 && i / 10 < nerr) b = ~b;
      @(negedge clk);
      bit_en = 1'b1; bit_in = b;
      gpos++;
      if (gap_mode != 0) begin
        @(negedge clk);
        bit_en = 1'b0; bit_in = ~b;
      end
    end
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int u0, d0;
    do_reset();
    #1;
    check(up_seen == 0 && dn_seen == 0 && loop_out == 0, "R9 reset outputs", int'(loop_out), 0);

    // Fixed codes, 2-window switching, automatic on
    det_sel = 2'b11; auto_en = 1'b1;
    u0 = up_cnt;
    send_window(0, 0);
    check(up_cnt == u0 + 1, "R4 fixed loop-up window flagged", up_cnt - u0, 1);
    check(loop_out == 0, "R6 one window not enough", int'(loop_out), 0);
    send_window(0, 0);
    check(loop_out == 1, "R7 loop set after two windows", int'(loop_out), 1);

    // Error threshold boundary
    u0 = up_cnt;
    send_window(0, EMAX);
    check(up_cnt == u0 + 1, "R2 ERR_MAX errors qualify", up_cnt - u0, 1);
    u0 = up_cnt;
    send_window(0, EMAX + 1);
    check(up_cnt == u0, "R2 ERR_MAX+1 errors rejected", up_cnt - u0, 0);

    // Fixed loop-down clears the loop
    d0 = dn_cnt;
    send_window(1, 0);
    send_window(1, 1);
    check(dn_cnt == d0 + 2, "R4 fixed loop-down flagged", dn_cnt - d0, 2);
    check(loop_out == 0, "R7 loop cleared by loop-down run", int'(loop_out), 1'b0);

    // Restart on a non-qualifying window
    send_window(0, 0);
    send_window(2, 0);
    send_window(0, 0);
    check(loop_out == 0, "R6 interrupted run does not switch", int'(loop_out), 0);

    // Automatic switching disabled: flags still raised
    auto_en = 1'b0;
    u0 = up_cnt;
    repeat (3) send_window(0, 0);
    check(up_cnt == u0 + 3 && loop_out == 0, "R7 auto off keeps loop", int'(loop_out), 0);

    // Software request ORed in
    sw_loop = 1'b1;
    #1;
    check(loop_out == 1, "R8 software request", int'(loop_out), 1);
    @(negedge clk);
    sw_loop = 1'b0;

    // 16-window setting, with idle gaps between bits
    auto_en = 1'b1; det_sel = 2'b00; gap_mode = 1;
    send_window(2, 0);
    repeat (15) send_window(0, 0);
    check(loop_out == 0, "R6 fifteen windows not enough", int'(loop_out), 0);
    send_window(0, 0);
    check(loop_out == 1, "R1 R6 sixteenth window switches", int'(loop_out), 1);
    gap_mode = 0;

    // 4-window setting for loop-down
    det_sel = 2'b10;
    repeat (3) send_window(1, 0);
    check(loop_out == 1, "R6 three of four windows", int'(loop_out), 1);
    send_window(1, 0);
    check(loop_out == 0, "R6 fourth window clears", int'(loop_out), 0);

    // Programmable codes: length 2 and length 8
    prog_mode = 1'b1;
    up_pat = 8'b0000_0001; up_len = 3'd0;
    dn_pat = 8'b0001_0011; dn_len = 3'd7;
    det_sel = 2'b11;
    do_reset();
    u0 = up_cnt; d0 = dn_cnt;
    repeat (2) send_window(0, 0);
    check(up_cnt == u0 + 2 && loop_out == 1, "R5 length-2 code switches", up_cnt - u0, 2);
    repeat (2) send_window(1, 0);
    check(dn_cnt == d0 + 2 && loop_out == 0, "R5 length-8 code switches", dn_cnt - d0, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule